// File: doc/BRIEF.md
# SDRAM Bank Command Legality Monitor

This block sits beside an SDRAM controller and watches the command bus on every rising clock edge. It decodes each command from the chip select, row strobe, column strobe and write enable levels, keeps a state and a cycle countdown for each bank, and flags any command that the addressed bank (or the device as a whole) cannot accept at that moment. Minimum gaps between commands are parameters counted in clock cycles, so the same monitor covers any clock rate once the nanosecond limits are converted.

A flagged command produces a one-cycle pulse on the cycle after it was sampled. The pulse carries a rule code and the bank it concerns. An illegal command never moves a bank state. Bank states are exported so that an integrator or bench can observe what the monitor believes about the device.

Top module: `sdram_bank_monitor`

## Requirements
- R1: A cycle with chip select high, with clock enable low, or with the no-operation pattern (row, column and write strobes all high) is never flagged and changes no bank state.
- R2: An accepted row open (row strobe low, column and write strobes high) moves an idle bank to OPENING (state code 1) for T_RCD cycles and then to OPEN (code 2). Any open, read, write or close to that bank before then is flagged with rule 4 (bank busy).
- R3: A read (column strobe low, write strobe high) or write (column and write strobes low) to an idle bank is flagged with rule 6. A row open to an OPEN bank is flagged with rule 5.
- R4: An accepted close (row and write strobes low, column strobe high) moves an OPEN bank to CLOSING (code 6) for T_RP cycles and then to IDLE (code 0). With a10_i high it applies to every bank, and the first offending bank, lowest index first, is reported. A close to an OPENING bank is flagged with rule 4.
- R5: A read with a10_i high puts the bank in READ_AP (code 3) for BURST_LEN cycles, then CLOSING for T_RP cycles, then IDLE. During READ_AP a burst stop (only the write strobe low) or any command to that bank is flagged with rule 3.
- R6: A write with a10_i high puts the bank in WRITE_AP (code 4) for BURST_LEN cycles, then WRITE_RECOVERY (code 5) for T_WR cycles, then CLOSING for T_RP cycles, then IDLE. Commands to the bank during recovery are flagged with rule 4.
- R7: Refresh (row and column strobes low, write strobe high) and mode set (all three strobes low) are flagged with rule 2 when any bank is not IDLE, reporting the lowest such bank.
- R8: After an accepted refresh, every command other than a no-operation is flagged with rule 1 for T_RC cycles. After an accepted mode set, the same holds for T_RSC cycles.
- R9: A row open to an otherwise idle bank within T_RRD cycles of the previous accepted row open is flagged with rule 7.
- R10: The flag pulse is high for exactly the cycle after the offending command, with viol_rule_o nonzero and viol_bank_o naming the bank. The rejected command leaves every bank state unchanged.
- R11: After reset the flag is low and every bank reads IDLE (code 0). State code 7 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock, commands sampled on rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| cke_i | input | 1 | Clock enable; low cycles are ignored |
| ba_i | input | BA_W | Bank address |
| a10_i | input | 1 | Auto-close on read/write, all-bank on close |
| viol_o | output | 1 | One-cycle violation pulse |
| viol_rule_o | output | 3 | Rule code of the violation (0 when none) |
| viol_bank_o | output | BA_W | Bank the violation concerns |
| bank_state_o | output | 3*NB | Bank state codes, bank i at bits 3i+2:3i |

## Verification
A bank state or countdown that is wrong shows in two places. It shows on bank_state_o one cycle after the edge where it went wrong. It also shows on the flag one cycle after the next command that the bad state would wrongly reject or accept. Stale global or row-open gap timers are only visible when a command lands inside the window, so the tests place commands exactly at the last illegal edge and at the first legal edge of each window. Checking that a rejected command leaves the bank states alone catches any update that is not gated by legality.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

  typedef enum logic [2:0] {
    CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_REF, CMD_MRS, CMD_TERM
  } cmd_e;

  typedef enum logic [2:0] {
    BS_IDLE     = 3'd0,
    BS_OPENING  = 3'd1,
    BS_OPEN     = 3'd2,
    BS_RD_AP    = 3'd3,
    BS_WR_AP    = 3'd4,
    BS_WR_RECOV = 3'd5,
    BS_CLOSING  = 3'd6
  } bank_st_e;

  typedef enum logic [2:0] {
    RULE_NONE        = 3'd0,
    RULE_GLOBAL_BUSY = 3'd1,
    RULE_ALL_IDLE    = 3'd2,
    RULE_AP_BURST    = 3'd3,
    RULE_BANK_BUSY   = 3'd4,
    RULE_NOT_IDLE    = 3'd5,
    RULE_NOT_OPEN    = 3'd6,
    RULE_RRD         = 3'd7
  } rule_e;

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // per-bank legality of a bank-addressed command
  function automatic rule_e bank_rule(cmd_e c, bank_st_e s);
    rule_e r;
    r = RULE_NONE;
    if (s == BS_RD_AP || s == BS_WR_AP) r = RULE_AP_BURST;
    else if (s == BS_OPENING || s == BS_WR_RECOV) r = RULE_BANK_BUSY;
    else begin
      case (c)
        CMD_ACT: begin
          if (s == BS_CLOSING) r = RULE_BANK_BUSY;
          else if (s == BS_OPEN) r = RULE_NOT_IDLE;
        end
        CMD_RD, CMD_WR: begin
          if (s == BS_CLOSING) r = RULE_BANK_BUSY;
          else if (s == BS_IDLE) r = RULE_NOT_OPEN;
        end
        default: r = RULE_NONE;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_mon_pkg::*;
(
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  input  logic cke_i,
  output cmd_e cmd_o
);
  always_comb begin
    cmd_o = CMD_NOP;
    if (!cs_ni && cke_i) begin
      case ({ras_ni, cas_ni, we_ni})
        3'b011:  cmd_o = CMD_ACT;
        3'b101:  cmd_o = CMD_RD;
        3'b100:  cmd_o = CMD_WR;
        3'b010:  cmd_o = CMD_PRE;
        3'b001:  cmd_o = CMD_REF;
        3'b000:  cmd_o = CMD_MRS;
        3'b110:  cmd_o = CMD_TERM;
        default: cmd_o = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         busy_o
);
  logic [W-1:0] cnt_q;

  assign busy_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= val_i;
    else if (busy_o) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/sdram_bank_fsm.sv
module sdram_bank_fsm
  import sdram_mon_pkg::*;
#(
  parameter int T_RCD     = 2,
  parameter int T_RP      = 2,
  parameter int T_WR      = 2,
  parameter int BURST_LEN = 4,
  parameter int TW        = 3
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  cmd_e     cmd_i,
  input  logic     hit_i,
  input  logic     a10_i,
  input  logic     legal_i,
  output bank_st_e state_o
);
  typedef struct packed {
    bank_st_e        st;
    logic [TW-1:0]   t;
  } slot_t;

  // timer value = further edges the state is seen; zero chains to successor
  function automatic slot_t enter(bank_st_e s, logic [TW-1:0] c);
    slot_t r;
    r.st = s;
    r.t  = c;
    if (c == '0) begin
      case (s)
        BS_OPENING:            r.st = BS_OPEN;
        BS_CLOSING:            r.st = BS_IDLE;
        BS_RD_AP, BS_WR_RECOV: begin r.st = BS_CLOSING;  r.t = TW'(T_RP); end
        BS_WR_AP:              begin r.st = BS_WR_RECOV; r.t = TW'(T_WR); end
        default:               r.t = '0;
      endcase
    end
    return r;
  endfunction

  slot_t cur_q, nxt;
  logic  transient;

  assign transient = (cur_q.st != BS_IDLE) && (cur_q.st != BS_OPEN);
  assign state_o   = cur_q.st;

  always_comb begin
    nxt = cur_q;
    if (transient) nxt = enter(cur_q.st, cur_q.t - 1'b1);
    if (legal_i && hit_i) begin
      case (cmd_i)
        CMD_ACT: nxt = enter(BS_OPENING, TW'(T_RCD - 1));
        CMD_RD:  if (a10_i) nxt = enter(BS_RD_AP, TW'(BURST_LEN - 1));
        CMD_WR:  if (a10_i) nxt = enter(BS_WR_AP, TW'(BURST_LEN - 1));
        CMD_PRE: if (cur_q.st == BS_OPEN) nxt = enter(BS_CLOSING, TW'(T_RP - 1));
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cur_q <= '{st: BS_IDLE, t: '0};
    else         cur_q <= nxt;
  end
endmodule

// File: rtl/sdram_bank_monitor.sv
module sdram_bank_monitor
  import sdram_mon_pkg::*;
#(
  parameter int NB        = 2,
  parameter int T_RCD     = 2,
  parameter int T_RP      = 2,
  parameter int T_RC      = 7,
  parameter int T_WR      = 2,
  parameter int T_RRD     = 2,
  parameter int T_RSC     = 2,
  parameter int BURST_LEN = 4,
  localparam int BA_W     = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cs_ni,
  input  logic            ras_ni,
  input  logic            cas_ni,
  input  logic            we_ni,
  input  logic            cke_i,
  input  logic [BA_W-1:0] ba_i,
  input  logic            a10_i,
  output logic            viol_o,
  output logic [2:0]      viol_rule_o,
  output logic [BA_W-1:0] viol_bank_o,
  output logic [NB*3-1:0] bank_state_o
);
  localparam int TW = $clog2(imax(imax(T_RCD, T_RP), imax(T_WR, BURST_LEN)) + 1);
  localparam int GW = $clog2(imax(T_RC, T_RSC) + 1);
  localparam int RW = $clog2(T_RRD + 1);

  cmd_e            cmd;
  bank_st_e        st [NB];
  rule_e           rule;
  logic [BA_W-1:0] rbank;
  logic            legal, busy_g, busy_rrd;

  sdram_cmd_decode u_dec (
    .cs_ni (cs_ni), .ras_ni(ras_ni), .cas_ni(cas_ni), .we_ni(we_ni),
    .cke_i (cke_i), .cmd_o (cmd)
  );

  // refresh / mode-set quiet window (R8)
  sdram_gap_timer #(.W(GW)) u_gap_glob (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .load_i(legal && (cmd == CMD_REF || cmd == CMD_MRS)),
    .val_i ((cmd == CMD_REF) ? GW'(T_RC - 1) : GW'(T_RSC - 1)),
    .busy_o(busy_g)
  );

  // row-open to row-open spacing (R9)
  sdram_gap_timer #(.W(RW)) u_gap_rrd (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .load_i(legal && cmd == CMD_ACT),
    .val_i (RW'(T_RRD - 1)),
    .busy_o(busy_rrd)
  );

  always_comb begin
    rule  = RULE_NONE;
    rbank = ba_i;
    if (cmd != CMD_NOP) begin
      if (busy_g) rule = RULE_GLOBAL_BUSY;
      else begin
        case (cmd)
          CMD_REF, CMD_MRS: begin
            for (int i = NB - 1; i >= 0; i--)
              if (st[i] != BS_IDLE) begin rule = RULE_ALL_IDLE; rbank = BA_W'(i); end
          end
          CMD_TERM: begin
            for (int i = NB - 1; i >= 0; i--)
              if (st[i] == BS_RD_AP || st[i] == BS_WR_AP) begin
                rule = RULE_AP_BURST; rbank = BA_W'(i);
              end
          end
          CMD_PRE: begin
            if (a10_i) begin
              for (int i = NB - 1; i >= 0; i--)
                if (bank_rule(CMD_PRE, st[i]) != RULE_NONE) begin
                  rule = bank_rule(CMD_PRE, st[i]); rbank = BA_W'(i);
                end
            end else rule = bank_rule(CMD_PRE, st[ba_i]);
          end
          default: begin
            rule = bank_rule(cmd, st[ba_i]);
            if (cmd == CMD_ACT && rule == RULE_NONE && busy_rrd) rule = RULE_RRD;
          end
        endcase
      end
    end
  end

  assign legal = (rule == RULE_NONE);

  for (genvar i = 0; i < NB; i++) begin : g_bank
    sdram_bank_fsm #(
      .T_RCD(T_RCD), .T_RP(T_RP), .T_WR(T_WR), .BURST_LEN(BURST_LEN), .TW(TW)
    ) u_fsm (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cmd_i  (cmd),
      .hit_i  ((ba_i == BA_W'(i)) || (cmd == CMD_PRE && a10_i)),
      .a10_i  (a10_i),
      .legal_i(legal),
      .state_o(st[i])
    );
    assign bank_state_o[3*i +: 3] = st[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      viol_o      <= 1'b0;
      viol_rule_o <= '0;
      viol_bank_o <= '0;
    end else begin
      viol_o      <= !legal;
      viol_rule_o <= rule;
      viol_bank_o <= legal ? '0 : rbank;
    end
  end
endmodule

// File: rtl/sdram_bank_monitor_chk.sv
module sdram_bank_monitor_chk #(
  parameter int NB   = 2,
  parameter int BA_W = 1
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cs_ni,
  input logic            ras_ni,
  input logic            cas_ni,
  input logic            we_ni,
  input logic            cke_i,
  input logic [BA_W-1:0] ba_i,
  input logic            viol_o,
  input logic [2:0]      viol_rule_o,
  input logic [NB*3-1:0] bank_state_o
);
  logic sel;
  assign sel = !cs_ni && cke_i;

  assert_quiet_nop_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel || (ras_ni && cas_ni && we_ni)) |=> !viol_o);

  assert_rule_set_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> (viol_rule_o != 3'd0));

  assert_open_from_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel && !ras_ni && cas_ni && we_ni && ba_i == '0 && bank_state_o[2:0] == 3'd0)
      |=> (viol_o || bank_state_o[2:0] == 3'd1 || bank_state_o[2:0] == 3'd2));

  assert_reopen_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel && !ras_ni && cas_ni && we_ni && ba_i == '0 && bank_state_o[2:0] == 3'd2)
      |=> (viol_o && bank_state_o[2:0] == 3'd2));

  assert_refresh_needs_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel && !ras_ni && !cas_ni && bank_state_o != '0) |=> viol_o);

  for (genvar i = 0; i < NB; i++) begin : g_code
    assert_state_code_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bank_state_o[3*i +: 3] != 3'd7);
  end
endmodule

bind sdram_bank_monitor sdram_bank_monitor_chk #(.NB(NB), .BA_W(BA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_ni       (cs_ni),
  .ras_ni      (ras_ni),
  .cas_ni      (cas_ni),
  .we_ni       (we_ni),
  .cke_i       (cke_i),
  .ba_i        (ba_i),
  .viol_o      (viol_o),
  .viol_rule_o (viol_rule_o),
  .bank_state_o(bank_state_o)
);

// File: tb/tb_sdram_bank_monitor.sv
module tb_sdram_bank_monitor;
  localparam logic [2:0] C_NOP = 0, C_ACT = 1, C_RD = 2, C_WR = 3,
                         C_PRE = 4, C_REF = 5, C_MRS = 6, C_TERM = 7;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_ni = 1'b1, ras_ni = 1'b1, cas_ni = 1'b1, we_ni = 1'b1, cke_i = 1'b1;
  logic [0:0] ba_i = '0;
  logic       a10_i = 1'b0;
  logic       viol_o;
  logic [2:0] viol_rule_o;
  logic [0:0] viol_bank_o;
  logic [5:0] bank_state_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  sdram_bank_monitor dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .ras_ni(ras_ni), .cas_ni(cas_ni),
    .we_ni(we_ni), .cke_i(cke_i), .ba_i(ba_i), .a10_i(a10_i), .viol_o(viol_o),
    .viol_rule_o(viol_rule_o), .viol_bank_o(viol_bank_o), .bank_state_o(bank_state_o)
  );

  task automatic drive_raw(input logic cs, input logic ck, input logic [2:0] rcw,
                           input int b, input logic a);
    cs_ni = cs; cke_i = ck; {ras_ni, cas_ni, we_ni} = rcw; ba_i = 1'(b); a10_i = a;
    @(negedge clk_i);
  endtask

  task automatic issue(input logic [2:0] c, input int b = 0, input logic a = 1'b0);
    logic [2:0] rcw;
    case (c)
      C_ACT:   rcw = 3'b011;
      C_RD:    rcw = 3'b101;
      C_WR:    rcw = 3'b100;
      C_PRE:   rcw = 3'b010;
      C_REF:   rcw = 3'b001;
      C_MRS:   rcw = 3'b000;
      C_TERM:  rcw = 3'b110;
      default: rcw = 3'b111;
    endcase
    drive_raw(1'b0, 1'b1, rcw, b, a);
  endtask

  task automatic nops(input int n);
    for (int k = 0; k < n; k++) issue(C_NOP);
  endtask

  task automatic expect_v(input string tag, input logic ev, input int er = 0, input int eb = 0);
    n_checks++;
    if (ev ? (viol_o !== 1'b1 || viol_rule_o !== 3'(er) || viol_bank_o !== 1'(eb))
           : (viol_o !== 1'b0)) begin
      n_errors++;
      $display("FAIL %s: viol=%0b rule=%0d bank=%0d expected viol=%0b rule=%0d bank=%0d",
               tag, viol_o, viol_rule_o, viol_bank_o, ev, er, eb);
    end
  endtask

  task automatic expect_st(input string tag, input int b, input int es);
    n_checks++;
    if (bank_state_o[3*b +: 3] !== 3'(es)) begin
      n_errors++;
      $display("FAIL %s: bank%0d state=%0d expected %0d", tag, b, bank_state_o[3*b +: 3], es);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    drive_raw(1'b1, 1'b1, 3'b111, 0, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic test_reset();
    do_reset();
    expect_v("R11 reset flag", 1'b0);
    expect_st("R11 reset bank0", 0, 0);
    expect_st("R11 reset bank1", 1, 0);
  endtask

  task automatic test_open();
    do_reset();
    issue(C_ACT, 0); expect_v("R2 act", 1'b0); expect_st("R2 opening", 0, 1);
    issue(C_RD, 0);  expect_v("R2 read in tRCD", 1'b1, 4, 0); expect_st("R2 now open", 0, 2);
    issue(C_RD, 0);  expect_v("R2 read after tRCD", 1'b0); expect_st("R2 plain read keeps open", 0, 2);
  endtask

  task automatic test_rrd();
    do_reset();
    issue(C_ACT, 0);
    issue(C_ACT, 1); expect_v("R9 act in tRRD", 1'b1, 7, 1);
    expect_st("R10 rejected act leaves bank1", 1, 0);
    issue(C_ACT, 1); expect_v("R9 act after tRRD", 1'b0); expect_st("R9 bank1 opening", 1, 1);
    issue(C_NOP);    expect_v("R10 pulse one cycle", 1'b0);
  endtask

  task automatic test_need_open();
    do_reset();
    issue(C_RD, 1); expect_v("R3 read idle", 1'b1, 6, 1);
    issue(C_WR, 0); expect_v("R3 write idle", 1'b1, 6, 0);
    issue(C_ACT, 0); nops(1);
    issue(C_ACT, 0); expect_v("R3 act open bank", 1'b1, 5, 0);
    expect_st("R10 open bank unchanged", 0, 2);
  endtask

  task automatic test_close();
    do_reset();
    issue(C_ACT, 0); nops(1);
    issue(C_ACT, 1); nops(1);
    issue(C_PRE, 0); expect_v("R4 pre single", 1'b0);
    expect_st("R4 bank0 closing", 0, 6); expect_st("R4 bank1 untouched", 1, 2);
    nops(1); expect_st("R4 bank0 idle after tRP", 0, 0);
    issue(C_PRE, 0, 1'b1); expect_v("R4 pre all", 1'b0); expect_st("R4 pre all bank1", 1, 6);
    nops(1); expect_st("R4 bank1 idle", 1, 0);
    issue(C_ACT, 0);
    issue(C_PRE, 0); expect_v("R4 pre on opening", 1'b1, 4, 0);
    issue(C_ACT, 1);
    issue(C_PRE, 0, 1'b1); expect_v("R4 pre all reports bank1", 1'b1, 4, 1);
  endtask

  task automatic test_read_ap();
    do_reset();
    issue(C_ACT, 0); nops(1);
    issue(C_RD, 0, 1'b1); expect_v("R5 read ap", 1'b0); expect_st("R5 read ap state", 0, 3);
    issue(C_TERM);   expect_v("R5 stop in ap burst", 1'b1, 3, 0);
    issue(C_RD, 0);  expect_v("R5 read in ap burst", 1'b1, 3, 0);
    nops(1);         expect_st("R5 closing after burst", 0, 6);
    issue(C_ACT, 0); expect_v("R5 act while closing", 1'b1, 4, 0);
    nops(1);         expect_st("R5 idle after tRP", 0, 0);
    issue(C_ACT, 0); expect_v("R5 act when idle", 1'b0);
  endtask

  task automatic test_write_ap();
    do_reset();
    issue(C_ACT, 0); nops(1);
    issue(C_WR, 0, 1'b1); expect_st("R6 write ap state", 0, 4);
    nops(3);         expect_st("R6 recovery state", 0, 5);
    issue(C_PRE, 0); expect_v("R6 pre in recovery", 1'b1, 4, 0);
    expect_st("R6 still recovering", 0, 5);
    nops(1);         expect_st("R6 closing", 0, 6);
    nops(2);         expect_st("R6 idle", 0, 0);
  endtask

  task automatic test_refresh();
    do_reset();
    issue(C_ACT, 1);
    issue(C_REF);    expect_v("R7 refresh not idle", 1'b1, 2, 1);
    nops(1);
    issue(C_PRE, 0, 1'b1); nops(1);
    issue(C_REF);    expect_v("R7 refresh all idle", 1'b0);
    issue(C_ACT, 0); expect_v("R8 act in tRC", 1'b1, 1, 0);
    nops(4);
    issue(C_RD, 1);  expect_v("R8 last edge of tRC", 1'b1, 1, 1);
    issue(C_ACT, 0); expect_v("R8 act after tRC", 1'b0); expect_st("R8 bank0 opening", 0, 1);
  endtask

  task automatic test_mrs();
    do_reset();
    issue(C_MRS);    expect_v("R7 mode set idle", 1'b0);
    issue(C_ACT, 0); expect_v("R8 act in tRSC", 1'b1, 1, 0);
    issue(C_ACT, 0); expect_v("R8 act after tRSC", 1'b0);
    issue(C_MRS);    expect_v("R7 mode set not idle", 1'b1, 2, 0);
    expect_st("R10 mode set reject keeps bank", 0, 2);
  endtask

  task automatic test_ignored();
    do_reset();
    issue(C_ACT, 0); nops(1);
    drive_raw(1'b1, 1'b1, 3'b011, 0, 1'b0); expect_v("R1 deselect act", 1'b0);
    expect_st("R1 deselect no change", 0, 2);
    drive_raw(1'b0, 1'b0, 3'b101, 1, 1'b0); expect_v("R1 cke low read", 1'b0);
    drive_raw(1'b0, 1'b0, 3'b001, 0, 1'b0); expect_v("R1 cke low refresh", 1'b0);
    expect_st("R1 bank1 still idle", 1, 0);
    issue(C_NOP);   expect_v("R1 nop", 1'b0);
  endtask

  initial begin
    @(negedge clk_i);
    test_reset();
    test_open();
    test_rrd();
    test_need_open();
    test_close();
    test_read_ap();
    test_write_ap();
    test_refresh();
    test_mrs();
    test_ignored();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule